// File: doc/BRIEF.md
# Dual-Bank Switch Matrix Controller

This block holds the closed/open state of two 16-switch banks (bank A and bank B) feeding a two-output analog multiplexer. Each bank's state sits in live registers whose bits drive the switch enables directly. A host reaches the block through a simple synchronous byte-wide register port with address, write data, write strobe, read strobe and registered read data.

Each bank has three kinds of register. Its live bytes can be written directly and take effect at once. Its staging bytes take a new pattern without touching the switches. Its command register acts on the whole bank. A command can close exactly one switch, open every switch, or move both staging bytes into the live state on a single clock edge, so the switches never pass through a mix of old and new bytes. The serial bus front end and the analog switches themselves sit outside this block.

Top module: `swmx_ctrl`

## Requirements
- R1: After reset every switch of both banks is open (`sw_a` = `sw_b` = 0) and every staging byte reads 0x00.
- R2: A write to a live byte takes effect on the next clock edge. Address 0x00 holds bank A bits 7:0 and 0x01 holds bank A bits 15:8. Address 0x02 holds bank B bits 7:0 and 0x03 holds bank B bits 15:8. Switch n of a bank is bit n-1 of its vector.
- R3: A read strobe returns its data in `reg_rdata` one cycle later, and a cycle with no read strobe yields 0x00 there. Reading a live byte returns the live switch state.
- R4: Staging bytes sit at 0x10–0x13 with the same bank/byte layout as the live bytes. Writing one leaves both switch vectors unchanged, and reading one returns the value written.
- R5: The bank A command register is at 0x14 and the bank B command register at 0x15. A code from 0 to 15 closes only switch code+1 of that bank and opens all its other switches.
- R6: Command code 17 loads both staging bytes of the bank into its live vector on a single clock edge.
- R7: Command code 16 opens every switch of the bank.
- R8: A command leaves the other bank's live vector unchanged.
- R9: Command codes 18 to 255 leave the bank unchanged.
- R10: Reads of either command register or of any unmapped address return 0x00.
- R11: Writes to unmapped addresses change neither the switch vectors nor any staging byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| sw_a | output | 16 | Live switch enables, bank A, bit 0 = switch 1 |
| sw_b | output | 16 | Live switch enables, bank B, bit 0 = switch 1 |

## Verification
The hardest case to reach is the atomic copy. It only means something when the staged bytes differ in both halves from the live state, and when the other bank holds a distinctive pattern that would show any leakage across banks. The bench first fills all four live bytes with asymmetric values. It then stages a different pattern in every staging byte and confirms that the outputs did not move. Only after that does it issue the copy on one bank and then the other, checking the full 16-bit vectors right after each command edge. Exclusive-select is also driven at both end codes, 0 and 15, to catch a shift that is off by one.

// File: rtl/swmx_pkg.sv
package swmx_pkg;

   // Class of a bank command after decoding
   typedef enum logic [1:0] {
      CMD_SEL  = 2'd0,   // close one switch, open the rest
      CMD_CLR  = 2'd1,   // open the whole bank
      CMD_COPY = 2'd2,   // staging -> live in one edge
      CMD_HOLD = 2'd3    // no effect
   } cmd_kind_e;

endpackage

// File: rtl/swmx_cmd_dec.sv
module swmx_cmd_dec
   import swmx_pkg::*;
#(
   parameter int SW_N   = 16,
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] code,
   output cmd_kind_e         kind,
   output logic [SW_N-1:0]   sel_vec
);
   localparam int CODE_CLR  = SW_N;
   localparam int CODE_COPY = SW_N + 1;

   always_comb begin
      sel_vec = '0;
      if (int'(code) < SW_N) begin
         kind = CMD_SEL;
         for (int i = 0; i < SW_N; i++) begin
            if (int'(code) == i) sel_vec[i] = 1'b1;
         end
      end else if (int'(code) == CODE_CLR) begin
         kind = CMD_CLR;
      end else if (int'(code) == CODE_COPY) begin
         kind = CMD_COPY;
      end else begin
         kind = CMD_HOLD;
      end
   end
endmodule

// File: rtl/swmx_addr_dec.sv
module swmx_addr_dec #(
   parameter int ADDR_W   = 8,
   parameter int NBANK    = 2,
   parameter int BYTES    = 2,
   parameter int DIR_BASE = 'h00,
   parameter int SHD_BASE = 'h10,
   parameter int CMD_BASE = 'h14
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic [NBANK*BYTES-1:0] dir_hit,
   output logic [NBANK*BYTES-1:0] shd_hit,
   output logic [NBANK-1:0]       cmd_hit
);
   localparam int NBYTES = NBANK * BYTES;

   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_byte
         assign dir_hit[gi] = (addr == ADDR_W'(DIR_BASE + gi));
         assign shd_hit[gi] = (addr == ADDR_W'(SHD_BASE + gi));
      end
      for (gi = 0; gi < NBANK; gi++) begin : g_cmd
         assign cmd_hit[gi] = (addr == ADDR_W'(CMD_BASE + gi));
      end
   endgenerate
endmodule

// File: rtl/swmx_bank.sv
module swmx_bank
   import swmx_pkg::*;
#(
   parameter int SW_N   = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SW_N/DATA_W-1:0] dir_we,
   input  logic [SW_N/DATA_W-1:0] shd_we,
   input  logic              cmd_we,
   output logic [SW_N-1:0]   live,
   output logic [SW_N-1:0]   shadow
);
   localparam int BYTES = SW_N / DATA_W;

   cmd_kind_e       kind;
   logic [SW_N-1:0] sel_vec;
   logic [SW_N-1:0] cmd_next;

   swmx_cmd_dec #(.SW_N(SW_N), .DATA_W(DATA_W)) u_dec (
      .code    (wdata),
      .kind    (kind),
      .sel_vec (sel_vec)
   );

   always_comb begin
      unique case (kind)
         CMD_SEL:  cmd_next = sel_vec;
         CMD_CLR:  cmd_next = '0;
         CMD_COPY: cmd_next = shadow;
         default:  cmd_next = live;
      endcase
   end

   // Live state: a bank command outranks byte writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live <= '0;
      end else if (cmd_we) begin
         live <= cmd_next;
      end else begin
         for (int j = 0; j < BYTES; j++) begin
            if (dir_we[j]) live[j*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   // Staging bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else begin
         for (int j = 0; j < BYTES; j++) begin
            if (shd_we[j]) shadow[j*DATA_W +: DATA_W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/swmx_ctrl.sv
module swmx_ctrl #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int SW_N     = 16,
   parameter int DIR_BASE = 'h00,
   parameter int SHD_BASE = 'h10,
   parameter int CMD_BASE = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [SW_N-1:0]   sw_a,
   output logic [SW_N-1:0]   sw_b
);
   localparam int NBANK  = 2;
   localparam int BYTES  = SW_N / DATA_W;
   localparam int NBYTES = NBANK * BYTES;

   generate
      if (SW_N % DATA_W != 0) begin : g_bad_width
         $error("SW_N must be a whole number of data bytes");
      end
      if (SW_N + 3 > (1 << DATA_W)) begin : g_bad_code
         $error("command codes do not fit the data width");
      end
      if (SHD_BASE < DIR_BASE + NBYTES || CMD_BASE < SHD_BASE + NBYTES) begin : g_bad_map
         $error("register regions overlap");
      end
   endgenerate

   logic [NBYTES-1:0] dir_hit, shd_hit;
   logic [NBANK-1:0]  cmd_hit;
   logic [SW_N-1:0]   live_v [NBANK];
   logic [SW_N-1:0]   shd_v  [NBANK];
   logic [SW_N-1:0]   shd_a_int, shd_b_int;
   logic [DATA_W-1:0] rd_mux;

   swmx_addr_dec #(
      .ADDR_W(ADDR_W), .NBANK(NBANK), .BYTES(BYTES),
      .DIR_BASE(DIR_BASE), .SHD_BASE(SHD_BASE), .CMD_BASE(CMD_BASE)
   ) u_adec (
      .addr    (reg_addr),
      .dir_hit (dir_hit),
      .shd_hit (shd_hit),
      .cmd_hit (cmd_hit)
   );

   genvar gb;
   generate
      for (gb = 0; gb < NBANK; gb++) begin : g_bank
         swmx_bank #(.SW_N(SW_N), .DATA_W(DATA_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wdata  (reg_wdata),
            .dir_we (dir_hit[gb*BYTES +: BYTES] & {BYTES{reg_wr}}),
            .shd_we (shd_hit[gb*BYTES +: BYTES] & {BYTES{reg_wr}}),
            .cmd_we (cmd_hit[gb] & reg_wr),
            .live   (live_v[gb]),
            .shadow (shd_v[gb])
         );
      end
   endgenerate

   assign sw_a      = live_v[0];
   assign sw_b      = live_v[1];
   assign shd_a_int = shd_v[0];
   assign shd_b_int = shd_v[1];

   // Command registers and holes read as zero by omission
   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (dir_hit[k]) rd_mux = live_v[k / BYTES][(k % BYTES)*DATA_W +: DATA_W];
         if (shd_hit[k]) rd_mux = shd_v[k / BYTES][(k % BYTES)*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= reg_rd ? rd_mux : '0;
   end
endmodule

// File: rtl/swmx_ctrl_chk.sv
module swmx_ctrl_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int SW_N     = 16,
   parameter int DIR_BASE = 'h00,
   parameter int SHD_BASE = 'h10,
   parameter int CMD_BASE = 'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [SW_N-1:0]   sw_a,
   input logic [SW_N-1:0]   sw_b,
   input logic [SW_N-1:0]   shd_a,
   input logic [SW_N-1:0]   shd_b
);
   localparam int NBYTES = 2 * (SW_N / DATA_W);

   logic wr_cmd_a, wr_shd;
   assign wr_cmd_a = reg_wr && (reg_addr == ADDR_W'(CMD_BASE));
   assign wr_shd   = reg_wr && (reg_addr >= ADDR_W'(SHD_BASE))
                            && (reg_addr <  ADDR_W'(SHD_BASE + NBYTES));

   a_r2_dir_low_a: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(DIR_BASE)) |=> sw_a[DATA_W-1:0] == $past(reg_wdata));

   a_r3_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(DIR_BASE)) |=> reg_rdata == $past(sw_a[DATA_W-1:0]));

   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> reg_rdata == '0);

   a_r4_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_shd |=> ($stable(sw_a) && $stable(sw_b)));

   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_a && int'(reg_wdata) < SW_N) |=>
         ($countones(sw_a) == 1 && sw_a == (SW_N'(1) << $past(reg_wdata))));

   a_r6_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_a && int'(reg_wdata) == SW_N + 1) |=> sw_a == $past(shd_a));

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_a && int'(reg_wdata) == SW_N) |=> sw_a == '0);

   a_r8_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd_a |=> $stable(sw_b));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd_a && int'(reg_wdata) >= SW_N + 2) |=> $stable(sw_a));

   a_r10_cmd_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == ADDR_W'(CMD_BASE) || reg_addr == ADDR_W'(CMD_BASE + 1)))
         |=> reg_rdata == '0);

   a_r11_shadow_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_shd |=> $stable(shd_b));
endmodule

bind swmx_ctrl swmx_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_N(SW_N),
   .DIR_BASE(DIR_BASE), .SHD_BASE(SHD_BASE), .CMD_BASE(CMD_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .sw_a      (sw_a),
   .sw_b      (sw_b),
   .shd_a     (shd_a_int),
   .shd_b     (shd_b_int)
);

// File: tb/swmx_ctrl_test.sv
`timescale 1ns/100ps
module swmx_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_rdata;
   logic [15:0] sw_a, sw_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swmx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .sw_a(sw_a), .sw_b(sw_b)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Inputs change on the falling edge; results are sampled one falling edge later
   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 sw_a after reset", 32'(sw_a), 32'h0);
      check("R1 sw_b after reset", 32'(sw_b), 32'h0);
      for (int i = 0; i < 4; i++) begin
         rd(8'h10 + 8'(i), d);
         check("R1 staging byte after reset", 32'(d), 32'h0);
      end
   endtask

   task automatic t_direct();
      logic [7:0] d;
      wr(8'h00, 8'hA5);
      check("R2 low byte A applied", 32'(sw_a), 32'h00A5);
      wr(8'h01, 8'h3C);
      wr(8'h02, 8'h81);
      wr(8'h03, 8'h7E);
      check("R2 bank A vector", 32'(sw_a), 32'h3CA5);
      check("R2 bank B vector", 32'(sw_b), 32'h7E81);
      rd(8'h01, d);
      check("R3 read live A high", 32'(d), 32'h3C);
      rd(8'h02, d);
      check("R3 read live B low", 32'(d), 32'h81);
      @(negedge clk);
      check("R3 idle rdata zero", 32'(reg_rdata), 32'h0);
   endtask

   task automatic t_stage();
      logic [7:0] d;
      wr(8'h10, 8'h12); wr(8'h11, 8'h34); wr(8'h12, 8'h56); wr(8'h13, 8'h78);
      check("R4 staging leaves A", 32'(sw_a), 32'h3CA5);
      check("R4 staging leaves B", 32'(sw_b), 32'h7E81);
      rd(8'h11, d);
      check("R4 read staging A high", 32'(d), 32'h34);
      rd(8'h12, d);
      check("R4 read staging B low", 32'(d), 32'h56);
   endtask

   task automatic t_copy();
      wr(8'h14, 8'd17);
      check("R6 copy bank A", 32'(sw_a), 32'h3412);
      check("R8 copy A leaves B", 32'(sw_b), 32'h7E81);
      wr(8'h15, 8'd17);
      check("R6 copy bank B", 32'(sw_b), 32'h7856);
      check("R8 copy B leaves A", 32'(sw_a), 32'h3412);
   endtask

   task automatic t_select();
      logic [7:0] d;
      wr(8'h14, 8'd0);
      check("R5 code 0 on A", 32'(sw_a), 32'h0001);
      wr(8'h14, 8'd15);
      check("R5 code 15 on A", 32'(sw_a), 32'h8000);
      wr(8'h14, 8'd7);
      check("R5 code 7 on A", 32'(sw_a), 32'h0080);
      wr(8'h15, 8'd9);
      check("R5 code 9 on B", 32'(sw_b), 32'h0200);
      check("R8 B command leaves A", 32'(sw_a), 32'h0080);
      rd(8'h14, d);
      check("R10 command A reads zero", 32'(d), 32'h0);
      rd(8'h15, d);
      check("R10 command B reads zero", 32'(d), 32'h0);
   endtask

   task automatic t_clear();
      wr(8'h14, 8'd16);
      check("R7 clear A", 32'(sw_a), 32'h0);
      check("R8 clear A leaves B", 32'(sw_b), 32'h0200);
      wr(8'h00, 8'hF0);
      wr(8'h15, 8'd16);
      check("R7 clear B", 32'(sw_b), 32'h0);
   endtask

   task automatic t_hold();
      wr(8'h14, 8'd18);
      check("R9 code 18 holds A", 32'(sw_a), 32'h00F0);
      wr(8'h14, 8'd19);
      check("R9 code 19 holds A", 32'(sw_a), 32'h00F0);
      wr(8'h14, 8'd255);
      check("R9 code 255 holds A", 32'(sw_a), 32'h00F0);
      wr(8'h03, 8'h5A);
      wr(8'h15, 8'd200);
      check("R9 code 200 holds B", 32'(sw_b), 32'h5A00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      for (int i = 0; i < 4; i++) begin
         case (i)
            0: wr(8'h04, 8'hFF);
            1: wr(8'h0F, 8'hFF);
            2: wr(8'h16, 8'hFF);
            default: wr(8'hFF, 8'hFF);
         endcase
      end
      check("R11 unmapped writes leave A", 32'(sw_a), 32'h00F0);
      check("R11 unmapped writes leave B", 32'(sw_b), 32'h5A00);
      rd(8'h10, d);
      check("R11 staging A low kept", 32'(d), 32'h12);
      rd(8'h13, d);
      check("R11 staging B high kept", 32'(d), 32'h78);
      rd(8'h04, d);
      check("R10 read 0x04 zero", 32'(d), 32'h0);
      rd(8'h20, d);
      check("R10 read 0x20 zero", 32'(d), 32'h0);
      rd(8'hFF, d);
      check("R10 read 0xFF zero", 32'(d), 32'h0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_stage();
      t_copy();
      t_select();
      t_clear();
      t_hold();
      t_unmapped();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule